// File: doc/BRIEF.md
# Power-On Default Register Programmer

This block loads a fixed set of register defaults into three serial slave devices as soon as the board comes out of reset. The three slaves are two analog front ends and one timing-generator chip. Each slave has its own active-low load strobe. All three share one serial clock and one data line. The block builds each write frame itself from parameter tables. It walks through every default register, then raises a done flag and gives the serial lines to an external steering path.

Every frame opens with a three-bit device code, most significant bit first: 001 for the first front end, 010 for the second and 011 for the timing generator. A low read/write bit follows the code. After that comes a device-specific address field. A front end takes a 3-bit register address, least significant bit first, then a test bit that is always low. The timing generator takes a 4-bit address, least significant bit first. The register value closes the frame, least significant bit first, at the data width of the target device.

The sequence runs again each time the board-reset input is pulsed and then released. While the sequence is running, the external serial inputs have no effect.

Top module: `cfg_boot_writer`

## Requirements
- R1: While `rst` is high, all three load lines are high, `ser_clk` and `ser_data` are low and `done` is low. After `rst` is released, programming starts without any further input, and `done` stays low until it completes.
- R2: While `board_rst` is high, `done` is low, all loads are high and `ser_clk` is low from the next cycle on. This holds even in the middle of a sequence. After `board_rst` falls, the complete sequence runs again from its first frame.
- R3: Frames come out in a fixed order. First the `AFE_NREG` registers of the first front end (load bit 0), then those of the second front end (load bit 1), then the `TG_NREG` registers of the timing generator (load bit 2). Within each device, addresses ascend from 0. During a frame exactly one load line is low.
- R4: The first four bits of a frame are the device code, most significant bit first (001, 010 or 011 for load bits 0, 1 and 2), followed by a 0.
- R5: In a front-end frame, bits 4 to 4+`AFE_AW`-1 carry the register address, least significant bit first, and the next bit is 0.
- R6: In a timing-generator frame, bits 4 to 4+`TG_AW`-1 carry the register address, least significant bit first.
- R7: The data field follows the header, least significant bit first. It is `AFE_DW` bits wide for a front end and `TG_DW` bits wide for the timing generator. The value is the slice of `AFE0_INIT`, `AFE1_INIT` or `TG_INIT` at bit offset address×width.
- R8: Within a frame, each bit period lasts `CLK_DIV` system cycles. `ser_clk` is low for the first `CLK_DIV`/2 cycles and high for the rest, and a slave samples one bit per rising edge. `ser_data` does not change while `ser_clk` is high.
- R9: Between frames, all loads stay high with `ser_clk` low for at least `CLK_DIV` system cycles.
- R10: While `done` is low, changes on `ext_load_n`, `ext_sclk` and `ext_sdata` do not alter any frame.
- R11: `done` rises only after the last frame's load has gone high and the closing gap has passed. It then stays high until a reset. Once `done` is high, the outputs repeat the external inputs with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| board_rst | input | 1 | Board reset request; programming restarts when it falls |
| ext_load_n | input | 3 | External steering path loads, active low (bit 0 front end 1, bit 1 front end 2, bit 2 timing generator) |
| ext_sclk | input | 1 | External steering path serial clock |
| ext_sdata | input | 1 | External steering path serial data |
| dev_load_n | output | 3 | Per-device load strobes, active low |
| ser_clk | output | 1 | Shared serial clock |
| ser_data | output | 1 | Shared serial data |
| done | output | 1 | High once all defaults are written |

## Verification
The properties assume that `board_rst` is synchronous to `clk` and needs no debouncing. They also assume that the external path is relevant only after `done`, so the serial-shape properties apply only while `done` is low. During every sequence, the bench drives the external inputs from a free-running pseudo-random pattern, so any leak onto the bus shows up as a corrupted frame. It drives the board reset both between sequences and in the middle of one. It uses an odd divide so that the two clock phases have unequal lengths.

// File: rtl/cfg_boot_writer_pkg.sv
package cfg_boot_writer_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_GAP   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } bw_state_e;

  // Device code width plus the read/write bit
  localparam int SEL_W    = 3;
  localparam int PREFIX_W = SEL_W + 1;
  localparam int NDEV     = 3;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfg_boot_writer_timer.sv
module cfg_boot_writer_timer #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic phase_hi,
  output logic bit_end
);
  localparam int CNT_W = $clog2(CLK_DIV);
  localparam int HALF  = CLK_DIV / 2;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == CNT_W'(CLK_DIV - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign phase_hi = run && (cnt >= CNT_W'(HALF));
  assign bit_end  = run && (cnt == CNT_W'(CLK_DIV - 1));

endmodule

// File: rtl/cfg_boot_writer_frame.sv
module cfg_boot_writer_frame
  import cfg_boot_writer_pkg::*;
#(
  parameter int AFE_AW   = 3,
  parameter int TG_AW    = 4,
  parameter int AFE_NREG = 4,
  parameter int TG_NREG  = 11,
  parameter int AFE_DW   = 12,
  parameter int TG_DW    = 16,
  parameter logic [AFE_NREG*AFE_DW-1:0] AFE0_INIT = '0,
  parameter logic [AFE_NREG*AFE_DW-1:0] AFE1_INIT = '0,
  parameter logic [TG_NREG*TG_DW-1:0]   TG_INIT   = '0,
  parameter int FIDX_W   = 5,
  parameter int FR_W     = 24,
  parameter int LEN_W    = 5
) (
  input  logic [FIDX_W-1:0] frame_idx,
  output logic [FR_W-1:0]   frame_bits,
  output logic [LEN_W-1:0]  frame_len,
  output logic [1:0]        dev_sel
);
  // Header lengths differ: the front ends carry a trailing test bit
  localparam int AFE_HDR = PREFIX_W + AFE_AW + 1;
  localparam int TG_HDR  = PREFIX_W + TG_AW;

  always_comb begin
    int fi;
    int ri;
    logic [SEL_W-1:0] code;
    fi = int'(frame_idx);
    frame_bits = '0;
    frame_len  = '0;
    if (fi < AFE_NREG) begin
      dev_sel = 2'd0;
      ri      = fi;
    end else if (fi < 2 * AFE_NREG) begin
      dev_sel = 2'd1;
      ri      = fi - AFE_NREG;
    end else begin
      dev_sel = 2'd2;
      ri      = fi - 2 * AFE_NREG;
    end
    code = SEL_W'(dev_sel) + 1'b1;
    // Device code goes out most significant bit first, then read/write low
    for (int k = 0; k < SEL_W; k++) begin
      frame_bits[k] = code[SEL_W-1-k];
    end
    frame_bits[SEL_W] = 1'b0;
    if (dev_sel != 2'd2) begin
      for (int i = 0; i < AFE_AW; i++) begin
        frame_bits[PREFIX_W+i] = ri[i];
      end
      frame_bits[PREFIX_W+AFE_AW] = 1'b0;
      if (ri < AFE_NREG) begin
        for (int j = 0; j < AFE_DW; j++) begin
          frame_bits[AFE_HDR+j] = (dev_sel == 2'd0) ? AFE0_INIT[ri*AFE_DW+j]
                                                    : AFE1_INIT[ri*AFE_DW+j];
        end
      end
      frame_len = LEN_W'(AFE_HDR + AFE_DW);
    end else begin
      for (int i = 0; i < TG_AW; i++) begin
        frame_bits[PREFIX_W+i] = ri[i];
      end
      if (ri < TG_NREG) begin
        for (int j = 0; j < TG_DW; j++) begin
          frame_bits[TG_HDR+j] = TG_INIT[ri*TG_DW+j];
        end
      end
      frame_len = LEN_W'(TG_HDR + TG_DW);
    end
  end

endmodule

// File: rtl/cfg_boot_writer_seq.sv
module cfg_boot_writer_seq
  import cfg_boot_writer_pkg::*;
#(
  parameter int NFRAMES = 19,
  parameter int FIDX_W  = 5,
  parameter int FR_W    = 24,
  parameter int LEN_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              bit_end,
  input  logic              phase_hi,
  input  logic [FR_W-1:0]   frame_bits,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [1:0]        dev_sel,
  output bw_state_e         state,
  output logic [FIDX_W-1:0] frame_idx,
  output logic [NDEV-1:0]   seq_load_n,
  output logic              seq_sclk,
  output logic              seq_sdata
);
  logic [LEN_W-1:0] bit_idx;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state     <= ST_HOLD;
      frame_idx <= '0;
      bit_idx   <= '0;
    end else begin
      case (state)
        ST_HOLD: state <= ST_GAP;
        ST_GAP: begin
          if (bit_end) begin
            bit_idx <= '0;
            state   <= (frame_idx == FIDX_W'(NFRAMES)) ? ST_DONE : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (bit_end) begin
            if (bit_idx == frame_len - 1'b1) begin
              bit_idx   <= '0;
              frame_idx <= frame_idx + 1'b1;
              state     <= ST_GAP;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    seq_load_n = '1;
    if (state == ST_SHIFT) begin
      case (dev_sel)
        2'd0:    seq_load_n[0] = 1'b0;
        2'd1:    seq_load_n[1] = 1'b0;
        default: seq_load_n[2] = 1'b0;
      endcase
    end
  end

  assign seq_sclk  = (state == ST_SHIFT) && phase_hi;
  assign seq_sdata = (state == ST_SHIFT) ? frame_bits[bit_idx] : 1'b0;

endmodule

// File: rtl/cfg_boot_writer_mux.sv
module cfg_boot_writer_mux
  import cfg_boot_writer_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            own_ext,
  input  logic [NDEV-1:0] seq_load_n,
  input  logic            seq_sclk,
  input  logic            seq_sdata,
  input  logic [NDEV-1:0] ext_load_n,
  input  logic            ext_sclk,
  input  logic            ext_sdata,
  output logic [NDEV-1:0] load_n_q,
  output logic            sclk_q,
  output logic            sdata_q,
  output logic            done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      load_n_q <= '1;
      sclk_q   <= 1'b0;
      sdata_q  <= 1'b0;
      done_q   <= 1'b0;
    end else if (own_ext) begin
      load_n_q <= ext_load_n;
      sclk_q   <= ext_sclk;
      sdata_q  <= ext_sdata;
      done_q   <= 1'b1;
    end else begin
      load_n_q <= seq_load_n;
      sclk_q   <= seq_sclk;
      sdata_q  <= seq_sdata;
      done_q   <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_boot_writer.sv
module cfg_boot_writer
  import cfg_boot_writer_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int AFE_AW   = 3,
  parameter int TG_AW    = 4,
  parameter int AFE_NREG = 4,
  parameter int TG_NREG  = 11,
  parameter int AFE_DW   = 12,
  parameter int TG_DW    = 16,
  parameter logic [AFE_NREG*AFE_DW-1:0] AFE0_INIT = '0,
  parameter logic [AFE_NREG*AFE_DW-1:0] AFE1_INIT = '0,
  parameter logic [TG_NREG*TG_DW-1:0]   TG_INIT   = '0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       board_rst,
  input  logic [2:0] ext_load_n,
  input  logic       ext_sclk,
  input  logic       ext_sdata,
  output logic [2:0] dev_load_n,
  output logic       ser_clk,
  output logic       ser_data,
  output logic       done
);
  localparam int NFRAMES = 2 * AFE_NREG + TG_NREG;
  localparam int FIDX_W  = $clog2(NFRAMES + 1);
  localparam int AFE_FR  = PREFIX_W + AFE_AW + 1 + AFE_DW;
  localparam int TG_FR   = PREFIX_W + TG_AW + TG_DW;
  localparam int FR_W    = imax(AFE_FR, TG_FR);
  localparam int LEN_W   = $clog2(FR_W + 1);

  logic              restart;
  bw_state_e         state;
  logic              phase_hi;
  logic              bit_end;
  logic [FIDX_W-1:0] frame_idx;
  logic [FR_W-1:0]   frame_bits;
  logic [LEN_W-1:0]  frame_len;
  logic [1:0]        dev_sel;
  logic [NDEV-1:0]   seq_load_n;
  logic              seq_sclk;
  logic              seq_sdata;

  assign restart = rst || board_rst;

  cfg_boot_writer_timer #(
    .CLK_DIV(CLK_DIV)
  ) u_timer (
    .clk     (clk),
    .rst     (restart),
    .run     ((state == ST_GAP) || (state == ST_SHIFT)),
    .phase_hi(phase_hi),
    .bit_end (bit_end)
  );

  cfg_boot_writer_frame #(
    .AFE_AW   (AFE_AW),
    .TG_AW    (TG_AW),
    .AFE_NREG (AFE_NREG),
    .TG_NREG  (TG_NREG),
    .AFE_DW   (AFE_DW),
    .TG_DW    (TG_DW),
    .AFE0_INIT(AFE0_INIT),
    .AFE1_INIT(AFE1_INIT),
    .TG_INIT  (TG_INIT),
    .FIDX_W   (FIDX_W),
    .FR_W     (FR_W),
    .LEN_W    (LEN_W)
  ) u_frame (
    .frame_idx (frame_idx),
    .frame_bits(frame_bits),
    .frame_len (frame_len),
    .dev_sel   (dev_sel)
  );

  cfg_boot_writer_seq #(
    .NFRAMES(NFRAMES),
    .FIDX_W (FIDX_W),
    .FR_W   (FR_W),
    .LEN_W  (LEN_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .abort     (board_rst),
    .bit_end   (bit_end),
    .phase_hi  (phase_hi),
    .frame_bits(frame_bits),
    .frame_len (frame_len),
    .dev_sel   (dev_sel),
    .state     (state),
    .frame_idx (frame_idx),
    .seq_load_n(seq_load_n),
    .seq_sclk  (seq_sclk),
    .seq_sdata (seq_sdata)
  );

  cfg_boot_writer_mux u_mux (
    .clk       (clk),
    .rst       (restart),
    .own_ext   (state == ST_DONE),
    .seq_load_n(seq_load_n),
    .seq_sclk  (seq_sclk),
    .seq_sdata (seq_sdata),
    .ext_load_n(ext_load_n),
    .ext_sclk  (ext_sclk),
    .ext_sdata (ext_sdata),
    .load_n_q  (dev_load_n),
    .sclk_q    (ser_clk),
    .sdata_q   (ser_data),
    .done_q    (done)
  );

endmodule

// File: rtl/cfg_boot_writer_chk.sv
module cfg_boot_writer_chk (
  input logic       clk,
  input logic       rst,
  input logic       board_rst,
  input logic [2:0] dev_load_n,
  input logic       ser_clk,
  input logic       ser_data,
  input logic       done
);
  // R3: a single device is addressed at a time while programming
  a_r3_one_device: assert property (@(posedge clk) disable iff (rst)
    !done |-> $onehot0(~dev_load_n));

  // R9: the serial clock is parked low whenever no load is active
  a_r9_sclk_parked: assert property (@(posedge clk) disable iff (rst)
    (!done && (&dev_load_n)) |-> !ser_clk);

  // R8: data holds still through the high phase of the serial clock
  a_r8_data_steady: assert property (@(posedge clk) disable iff (rst)
    (!done && ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  // R9: a load release is followed by at least one more idle cycle
  a_r9_gap_follows: assert property (@(posedge clk) disable iff (rst)
    (!done && $rose(&dev_load_n)) |=> ((&dev_load_n) || done));

  // R11: completion is sticky until a reset request
  a_r11_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !board_rst) |=> done);

  // R11: completion is preceded by an idle bus
  a_r11_done_after_release: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(&dev_load_n));

  // R2: a board reset request idles the bus and clears completion
  a_r2_abort_idle: assert property (@(posedge clk) disable iff (rst)
    board_rst |=> (!done && (&dev_load_n) && !ser_clk));

endmodule

bind cfg_boot_writer cfg_boot_writer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .board_rst (board_rst),
  .dev_load_n(dev_load_n),
  .ser_clk   (ser_clk),
  .ser_data  (ser_data),
  .done      (done)
);

// File: tb/tb_cfg_boot_writer.sv
`timescale 1ns/1ps
module tb_cfg_boot_writer;
  localparam int CLK_DIV  = 3;
  localparam int AFE_AW   = 3;
  localparam int TG_AW    = 4;
  localparam int AFE_NREG = 4;
  localparam int TG_NREG  = 11;
  localparam int AFE_DW   = 5;
  localparam int TG_DW    = 6;
  localparam int NFR      = 2 * AFE_NREG + TG_NREG;

  function automatic int init_val(input int dev, input int r);
    int x;
    x = dev * 13 + r * 7 + 9;
    return (dev < 2) ? (x % (1 << AFE_DW)) : (x % (1 << TG_DW));
  endfunction

  function automatic logic [AFE_NREG*AFE_DW-1:0] pack_afe(input int dev);
    logic [AFE_NREG*AFE_DW-1:0] v;
    v = '0;
    for (int r = 0; r < AFE_NREG; r++) v[r*AFE_DW +: AFE_DW] = AFE_DW'(init_val(dev, r));
    return v;
  endfunction

  function automatic logic [TG_NREG*TG_DW-1:0] pack_tg();
    logic [TG_NREG*TG_DW-1:0] v;
    v = '0;
    for (int r = 0; r < TG_NREG; r++) v[r*TG_DW +: TG_DW] = TG_DW'(init_val(2, r));
    return v;
  endfunction

  localparam logic [AFE_NREG*AFE_DW-1:0] P_AFE0 = pack_afe(0);
  localparam logic [AFE_NREG*AFE_DW-1:0] P_AFE1 = pack_afe(1);
  localparam logic [TG_NREG*TG_DW-1:0]   P_TG   = pack_tg();

  function automatic int exp_dev(input int f);
    return (f < AFE_NREG) ? 0 : ((f < 2 * AFE_NREG) ? 1 : 2);
  endfunction
  function automatic int exp_reg(input int f);
    return f - AFE_NREG * exp_dev(f) + ((exp_dev(f) == 2) ? 0 : 0);
  endfunction
  function automatic int exp_hdr(input int f);
    return (exp_dev(f) < 2) ? (4 + AFE_AW + 1) : (4 + TG_AW);
  endfunction
  function automatic int exp_len(input int f);
    return exp_hdr(f) + ((exp_dev(f) < 2) ? AFE_DW : TG_DW);
  endfunction
  function automatic logic [63:0] exp_bits(input int f);
    logic [63:0] v;
    int d;
    int r;
    int code;
    int val;
    d = exp_dev(f);
    r = exp_reg(f);
    code = d + 1;
    val = init_val(d, r);
    v = '0;
    v[0] = code[2];
    v[1] = code[1];
    v[2] = code[0];
    v[3] = 1'b0;
    if (d < 2) begin
      for (int i = 0; i < AFE_AW; i++) v[4+i] = r[i];
      v[4+AFE_AW] = 1'b0;
      for (int j = 0; j < AFE_DW; j++) v[exp_hdr(f)+j] = val[j];
    end else begin
      for (int i = 0; i < TG_AW; i++) v[4+i] = r[i];
      for (int j = 0; j < TG_DW; j++) v[exp_hdr(f)+j] = val[j];
    end
    return v;
  endfunction

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       board_rst = 1'b0;
  logic [2:0] ext_load_n = 3'b111;
  logic       ext_sclk = 1'b0;
  logic       ext_sdata = 1'b0;
  logic [2:0] dev_load_n;
  logic       ser_clk;
  logic       ser_data;
  logic       done;

  always #5 clk = ~clk;

  cfg_boot_writer #(
    .CLK_DIV  (CLK_DIV),
    .AFE_AW   (AFE_AW),
    .TG_AW    (TG_AW),
    .AFE_NREG (AFE_NREG),
    .TG_NREG  (TG_NREG),
    .AFE_DW   (AFE_DW),
    .TG_DW    (TG_DW),
    .AFE0_INIT(P_AFE0),
    .AFE1_INIT(P_AFE1),
    .TG_INIT  (P_TG)
  ) dut (
    .clk       (clk),
    .rst       (rst),
    .board_rst (board_rst),
    .ext_load_n(ext_load_n),
    .ext_sclk  (ext_sclk),
    .ext_sdata (ext_sdata),
    .dev_load_n(dev_load_n),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .done      (done)
  );

  // External path driver: pseudo-random while toggling, else a fixed pattern
  logic       ext_toggle = 1'b0;
  logic [4:0] ext_pat = 5'b00111;
  logic [7:0] lfsr = 8'h5a;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (ext_toggle) {ext_load_n, ext_sclk, ext_sdata} = lfsr[4:0];
    else            {ext_load_n, ext_sclk, ext_sdata} = ext_pat;
  end

  // Bus monitor: a serial slave model that rebuilds frames
  int mon_checks = 0;
  int mon_fails  = 0;
  int run_bad    = 0;
  int nframes    = 0;
  int nbits      = 0;
  int gap        = 0;
  int since_rise = 0;
  int cur_dev    = 0;
  bit first_rise = 1'b1;
  bit timing_ok  = 1'b1;
  bit dev_ok     = 1'b1;
  logic [63:0] cap = '0;
  logic prev_sclk = 1'b0;
  logic prev_data = 1'b0;
  logic prev_act  = 1'b0;
  logic prev_done = 1'b0;

  task automatic mcheck(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
    mon_checks++;
    if (!ok) begin
      mon_fails++;
      run_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int load_dev(input logic [2:0] l);
    case (l)
      3'b110:  return 0;
      3'b101:  return 1;
      3'b011:  return 2;
      default: return 7;
    endcase
  endfunction

  always @(negedge clk) begin
    logic act;
    int pre_bad;
    int adr_bad;
    int dat_bad;
    logic [63:0] e;
    act = ~&dev_load_n;
    if (rst || board_rst) begin
      nframes = 0;
      nbits = 0;
      gap = 0;
      act = 1'b0;
    end else if (!done) begin
      if (act && !prev_act) begin
        mcheck(gap >= CLK_DIV, "R9", "idle cycles before frame", gap, CLK_DIV);
        nbits = 0;
        cap = '0;
        cur_dev = load_dev(dev_load_n);
        first_rise = 1'b1;
        timing_ok = 1'b1;
        dev_ok = 1'b1;
      end
      if (act) begin
        if (load_dev(dev_load_n) != cur_dev) dev_ok = 1'b0;
        if (ser_clk && !prev_sclk) begin
          if (!first_rise && since_rise != CLK_DIV) timing_ok = 1'b0;
          if (nbits < 64) cap[nbits] = ser_data;
          nbits++;
          since_rise = 0;
          first_rise = 1'b0;
        end
        if (ser_clk && prev_sclk && ser_data != prev_data) timing_ok = 1'b0;
        if (first_rise && ser_clk) timing_ok = 1'b0;
      end
      if (!act && prev_act) begin
        if (nframes >= NFR) begin
          mcheck(1'b0, "R3", "extra frame index", nframes, NFR - 1);
        end else begin
          e = exp_bits(nframes);
          pre_bad = 0;
          adr_bad = 0;
          dat_bad = 0;
          for (int k = 0; k < exp_len(nframes); k++) begin
            if (cap[k] !== e[k]) begin
              if (k < 4) pre_bad++;
              else if (k < exp_hdr(nframes)) adr_bad++;
              else dat_bad++;
            end
          end
          mcheck(dev_ok && cur_dev == exp_dev(nframes), "R3", "device of frame",
                 cur_dev, exp_dev(nframes));
          mcheck(nbits == exp_len(nframes), "R3", "bits in frame", nbits, exp_len(nframes));
          mcheck(pre_bad == 0, "R4", "prefix bits", cap & 64'hf, e & 64'hf);
          if (exp_dev(nframes) < 2)
            mcheck(adr_bad == 0, "R5", "front-end address field", cap, e);
          else
            mcheck(adr_bad == 0, "R6", "timing-gen address field", cap, e);
          mcheck(dat_bad == 0, "R7", "data field", cap, e);
          mcheck(timing_ok, "R8", "bit timing", 0, 1);
        end
        nframes++;
        gap = 0;
      end
      if (!act) gap++;
      since_rise++;
    end
    if (done && !prev_done && !rst && !board_rst) begin
      mcheck(nframes == NFR, "R11", "frames before done", nframes, NFR);
      mcheck(!prev_act, "R11", "load active before done", prev_act, 0);
    end
    prev_sclk = ser_clk;
    prev_data = ser_data;
    prev_act  = act;
    prev_done = done;
  end

  // Main sequence
  int checks = 0;
  int fails  = 0;
  bit wd_fail = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic pulse_board_rst(input int cycles);
    @(posedge clk); #1 board_rst = 1'b1;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    check(!done && dev_load_n == 3'b111 && !ser_clk, "R2", "bus during board reset",
          {done, dev_load_n, ser_clk}, 5'b01110);
    @(posedge clk); #1 board_rst = 1'b0;
  endtask

  initial begin
    bit ok;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(dev_load_n == 3'b111 && !ser_clk && !ser_data && !done, "R1", "reset state",
          {dev_load_n, ser_clk, ser_data, done}, 6'b111000);
    ext_toggle = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    repeat (20) @(negedge clk);
    check(!done && dev_load_n != 3'b111, "R1", "programming under way",
          {done, dev_load_n}, 4'b0110);
    wait_done(ok);
    check(ok, "R1", "first sequence completes", ok, 1);
    check(run_bad == 0 && nframes == NFR, "R10", "frames intact under external noise",
          run_bad, 0);
    ext_toggle = 1'b0;

    // Ownership handed to the external path
    for (int p = 0; p < 32; p += 5) begin
      @(negedge clk) ext_pat = 5'(p);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check({dev_load_n, ser_clk, ser_data} == 5'(p) && done, "R11", "external path follows",
            {dev_load_n, ser_clk, ser_data}, p);
    end
    @(negedge clk) ext_pat = 5'b11100;

    // Board reset after completion reruns the sequence
    run_bad = 0;
    ext_toggle = 1'b1;
    pulse_board_rst(4);
    wait_done(ok);
    check(ok && nframes == NFR && run_bad == 0, "R2", "rerun after board reset",
          nframes, NFR);

    // Board reset in the middle of a sequence
    ext_toggle = 1'b0;
    repeat (3) @(posedge clk);
    run_bad = 0;
    ext_toggle = 1'b1;
    pulse_board_rst(3);
    repeat (250) @(posedge clk);
    check(!done, "R2", "mid-run done low", done, 0);
    pulse_board_rst(5);
    wait_done(ok);
    check(ok && nframes == NFR && run_bad == 0, "R2", "full rerun after abort",
          nframes, NFR);
    ext_toggle = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(done, "R11", "done sticky", done, 1);

    $display("[TB] %0d tests run, %0d failed", checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1'b1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks + mon_checks + 1, fails + mon_fails + 1);
    $finish;
  end

endmodule